// File: doc/BRIEF.md
# Cubic Residue Nonlinearity LMS Corrector

An open-loop residue amplifier adds third-order distortion to every residue it passes on. This block undoes that distortion in the digital domain. Each incoming residue code `r` leaves the block as `r - c*r^3`, where `c` is a signed cubic coefficient. The correction runs on a four-register pipeline, and the result is clamped to the residue range.

The coefficient is learned in the background by a least-mean-squares loop. A distance estimator outside this block measures the gap that an injected offset opens between the two residue curves, once for an outer coarse-code bin and once for an inner bin. It passes both distances to this block, together with a signed gradient weight. When the cubic term is fully cancelled, the two distances are equal. Their difference is therefore the error that drives the coefficient update, with a step of 2^-13.

A small state machine sequences each update through four states:
- `ST_LISTEN` waits for a distance pair.
- `ST_MULT` forms the error-times-weight product.
- `ST_COMMIT` writes the clamped coefficient.
- `ST_FROZEN` is entered whenever hold is high.

One instance serves one path of a split converter, and a second instance serves the other path. The hold input keeps the coefficient fixed, for example while a later correction stage settles.

Top module: `cubic_lms_corrector`

## Requirements
- R1: While `rst_n` is low, `coef_out` is 0, `res_out_vld` is 0 and the state machine is in `ST_LISTEN`.
- R2: The residue path uses RW=12, CW=16 and CF=14, and every rescaling is an arithmetic right shift, which rounds toward minus infinity. For a residue `r` accepted at a clock edge, with `c` equal to `coef_out` before that edge, the block computes the following chain and presents `r - t` on `res_out` after the third following edge:
  - `s = (r*r) >>> 11`
  - `u = (s*r) >>> 11`
  - `t = (c*u) >>> 14`
- R3: When `r - t` lies outside -2048..2047, `res_out` shows the nearer of those two limits.
- R4: `res_out_vld` equals `res_vld` delayed by four clock edges, and is 0 for the first four edges after reset.
- R5: In `ST_LISTEN`, with `dist_vld` and hold low, the block captures the error `e = dist_outer - dist_inner` and the weight `g = grad_wt`, and moves to `ST_MULT`. `ST_MULT` forms `e*g` and moves to `ST_COMMIT`. `ST_COMMIT` sets `coef_out` to `coef_out + ((e*g) >>> 13)` and returns to `ST_LISTEN`. The new value therefore appears after the third edge counted from the capture edge.
- R6: The coefficient update is clamped to -32768..32767.
- R7: Any edge at which hold is high moves the machine to `ST_FROZEN` and leaves `coef_out` unchanged. This abandons any update that was in flight.
- R8: `dist_vld` is ignored in `ST_MULT`, in `ST_COMMIT` and in `ST_FROZEN`. The first edge with hold low moves `ST_FROZEN` to `ST_LISTEN` without capturing.
- R9: An outer distance smaller than the inner distance, with a positive weight, moves the coefficient negative from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_in | input | RW (12) | Signed residue code from the stage |
| res_vld | input | 1 | Marks `res_in` as a valid sample |
| dist_outer | input | DW (16) | Signed distance estimate for an outer coarse-code bin |
| dist_inner | input | DW (16) | Signed distance estimate for an inner coarse-code bin |
| grad_wt | input | GW (16) | Signed gradient weight for the current distance pair |
| dist_vld | input | 1 | Offers a distance pair for one update |
| hold | input | 1 | Freezes the coefficient and the update machine |
| res_out | output | RW (12) | Corrected and clamped residue |
| res_out_vld | output | 1 | Valid flag aligned with `res_out` |
| coef_out | output | CW (16) | Current cubic coefficient, CF=14 fraction bits |

## Verification
A corrupted coefficient register shows on `coef_out` on the very next cycle. Within four cycles it also shows on every valid corrected residue whose cube is not zero, because each sample carries a snapshot of the coefficient through the pipeline. A state machine that loses its place does not show on any output right away. It shows after about three cycles, as a coefficient step that is missing, doubled or made from the wrong operands. The reference model tracks both outputs on every clock, so an update that is early, late or abandoned wrongly is caught at the exact cycle.

// File: rtl/cubic_pkg.sv
package cubic_pkg;

    typedef enum logic [1:0] {
        ST_LISTEN = 2'd0,
        ST_MULT   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_FROZEN = 2'd3
    } lms_state_t;

endpackage

// File: rtl/sat_narrow.sv
module sat_narrow #(
    parameter int IW = 20,
    parameter int OW = 16
) (
    input  logic signed [IW-1:0] din,
    output logic signed [OW-1:0] dout
);
    generate
        if (IW <= OW) begin : g_pass
            assign dout = OW'(din);
        end else begin : g_clip
            localparam int TW = IW - OW + 1;
            logic [TW-1:0] top_bits;
            logic          fits;
            assign top_bits = din[IW-1:OW-1];
            assign fits     = (&top_bits) | (~|top_bits);
            always_comb begin
                if (fits)
                    dout = din[OW-1:0];
                else if (din[IW-1])
                    dout = {1'b1, {(OW-1){1'b0}}};
                else
                    dout = {1'b0, {(OW-1){1'b1}}};
            end
        end
    endgenerate
endmodule

// File: rtl/cube_path.sv
module cube_path #(
    parameter int RW = 12,
    parameter int CW = 16,
    parameter int CF = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [RW-1:0] res_in,
    input  logic                 res_vld,
    input  logic signed [CW-1:0] coef,
    output logic signed [RW-1:0] res_out,
    output logic                 res_out_vld
);
    localparam int SW  = RW + 1;      // scaled square / cube
    localparam int QW  = 2 * RW;      // full square
    localparam int KW  = SW + RW;     // full cube product
    localparam int MW  = CW + SW;     // coefficient times cube
    localparam int DW2 = MW + 1;      // subtraction headroom

    logic signed [RW-1:0] r1, r2, r3;
    logic signed [CW-1:0] c1, c2;
    logic                 v1, v2, v3, v4;
    logic signed [SW-1:0] sq1, cu2;
    logic signed [MW-1:0] cr3;
    logic signed [RW-1:0] out4;

    logic signed [QW-1:0]  sq_full, sq_sh;
    logic signed [KW-1:0]  cu_full, cu_sh;
    logic signed [MW-1:0]  mc_full;
    logic signed [DW2-1:0] dif;
    logic signed [RW-1:0]  dif_sat;

    assign sq_full = QW'(res_in) * QW'(res_in);
    assign sq_sh   = sq_full >>> (RW - 1);
    assign cu_full = KW'(sq1) * KW'(r1);
    assign cu_sh   = cu_full >>> (RW - 1);
    assign mc_full = MW'(c2) * MW'(cu2);
    assign dif     = DW2'(r3) - DW2'(cr3);

    sat_narrow #(.IW(DW2), .OW(RW)) u_out_sat (
        .din  (dif),
        .dout (dif_sat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r1   <= '0;
            r2   <= '0;
            r3   <= '0;
            c1   <= '0;
            c2   <= '0;
            v1   <= 1'b0;
            v2   <= 1'b0;
            v3   <= 1'b0;
            v4   <= 1'b0;
            sq1  <= '0;
            cu2  <= '0;
            cr3  <= '0;
            out4 <= '0;
        end else begin
            // stage 1: square
            r1  <= res_in;
            c1  <= coef;
            v1  <= res_vld;
            sq1 <= sq_sh[SW-1:0];
            // stage 2: cube
            r2  <= r1;
            c2  <= c1;
            v2  <= v1;
            cu2 <= cu_sh[SW-1:0];
            // stage 3: scaled correction term
            r3  <= r2;
            v3  <= v2;
            cr3 <= mc_full >>> CF;
            // stage 4: subtract and clamp
            v4   <= v3;
            out4 <= dif_sat;
        end
    end

    assign res_out     = out4;
    assign res_out_vld = v4;
endmodule

// File: rtl/lms_ctrl.sv
module lms_ctrl
    import cubic_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GW    = 16,
    parameter int CW    = 16,
    parameter int SHIFT = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] dist_outer,
    input  logic signed [DW-1:0] dist_inner,
    input  logic signed [GW-1:0] grad_wt,
    input  logic                 dist_vld,
    input  logic                 hold,
    output logic signed [CW-1:0] coef,
    output lms_state_t           state
);
    localparam int EW   = DW + 1;
    localparam int PRW  = EW + GW;
    localparam int SUMW = ((PRW > CW) ? PRW : CW) + 1;

    lms_state_t st, st_nx;

    logic signed [EW-1:0]   e_q, e_nx;
    logic signed [GW-1:0]   g_q;
    logic signed [PRW-1:0]  p_q;
    logic signed [CW-1:0]   coef_q, coef_sat;
    logic signed [SUMW-1:0] coef_sum;

    assign e_nx     = EW'(dist_outer) - EW'(dist_inner);
    assign coef_sum = SUMW'(coef_q) + SUMW'(p_q >>> SHIFT);

    sat_narrow #(.IW(SUMW), .OW(CW)) u_coef_sat (
        .din  (coef_sum),
        .dout (coef_sat)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_LISTEN;
        else
            st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        if (hold) begin
            st_nx = ST_FROZEN;
        end else begin
            unique case (st)
                ST_LISTEN: if (dist_vld) st_nx = ST_MULT;
                ST_MULT:   st_nx = ST_COMMIT;
                ST_COMMIT: st_nx = ST_LISTEN;
                ST_FROZEN: st_nx = ST_LISTEN;
            endcase
        end
    end

    // per-state datapath actions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q    <= '0;
            g_q    <= '0;
            p_q    <= '0;
            coef_q <= '0;
        end else if (!hold) begin
            unique case (st)
                ST_LISTEN: begin
                    if (dist_vld) begin
                        e_q <= e_nx;
                        g_q <= grad_wt;
                    end
                end
                ST_MULT:   p_q <= PRW'(e_q) * PRW'(g_q);
                ST_COMMIT: coef_q <= coef_sat;
                ST_FROZEN: ;
            endcase
        end
    end

    assign coef  = coef_q;
    assign state = st;
endmodule

// File: rtl/cubic_lms_corrector.sv
module cubic_lms_corrector
    import cubic_pkg::*;
#(
    parameter int RW    = 12,
    parameter int DW    = 16,
    parameter int GW    = 16,
    parameter int CW    = 16,
    parameter int CF    = 14,
    parameter int SHIFT = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [RW-1:0] res_in,
    input  logic                 res_vld,
    input  logic signed [DW-1:0] dist_outer,
    input  logic signed [DW-1:0] dist_inner,
    input  logic signed [GW-1:0] grad_wt,
    input  logic                 dist_vld,
    input  logic                 hold,
    output logic signed [RW-1:0] res_out,
    output logic                 res_out_vld,
    output logic signed [CW-1:0] coef_out
);
    logic signed [CW-1:0] coef_w;
    lms_state_t           lms_st;

    lms_ctrl #(
        .DW(DW), .GW(GW), .CW(CW), .SHIFT(SHIFT)
    ) u_lms (
        .clk        (clk),
        .rst_n      (rst_n),
        .dist_outer (dist_outer),
        .dist_inner (dist_inner),
        .grad_wt    (grad_wt),
        .dist_vld   (dist_vld),
        .hold       (hold),
        .coef       (coef_w),
        .state      (lms_st)
    );

    cube_path #(
        .RW(RW), .CW(CW), .CF(CF)
    ) u_cube (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_in      (res_in),
        .res_vld     (res_vld),
        .coef        (coef_w),
        .res_out     (res_out),
        .res_out_vld (res_out_vld)
    );

    assign coef_out = coef_w;
endmodule

// File: rtl/cubic_lms_checker.sv
module cubic_lms_checker
    import cubic_pkg::*;
#(
    parameter int CW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 res_vld,
    input logic                 out_vld,
    input logic                 hold,
    input logic signed [CW-1:0] coef,
    input lms_state_t           st
);
    logic [2:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cyc <= '0;
        else if (cyc != 3'd7)
            cyc <= cyc + 3'd1;
    end

    // R4: valid flag trails the input flag by four edges
    a_r4_vld_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 3'd4) |-> (out_vld == $past(res_vld, 4)));

    // R5: the coefficient moves only out of the commit state
    a_r5_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(coef) |-> ($past(st) == ST_COMMIT));

    // R7: hold keeps the coefficient
    a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(coef));

    // R8: a product in flight always proceeds to commit unless held
    a_r8_busy_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MULT && !hold) |=> (st == ST_COMMIT));

    // R8: leaving the frozen state goes to listening, never straight to multiply
    a_r8_thaw_listen: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FROZEN && !hold) |=> (st == ST_LISTEN));
endmodule

bind cubic_lms_corrector cubic_lms_checker #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .res_vld (res_vld),
    .out_vld (res_out_vld),
    .hold    (hold),
    .coef    (coef_out),
    .st      (lms_st)
);

// File: tb/tb_cubic_lms_corrector.sv
module tb_cubic_lms_corrector;
    localparam int CLK_P = 10;
    localparam int RW = 12, DW = 16, GW = 16, CW = 16, CF = 14, SHIFT = 13;
    localparam longint RMAX = 2047, RMIN = -2048;
    localparam longint CMAX = 32767, CMIN = -32768;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [RW-1:0] res_in = '0;
    logic                 res_vld = 1'b0;
    logic signed [DW-1:0] dist_outer = '0, dist_inner = '0;
    logic signed [GW-1:0] grad_wt = '0;
    logic                 dist_vld = 1'b0, hold = 1'b0;
    logic signed [RW-1:0] res_out;
    logic                 res_out_vld;
    logic signed [CW-1:0] coef_out;

    always #(CLK_P/2) clk = ~clk;

    cubic_lms_corrector dut (
        .clk(clk), .rst_n(rst_n), .res_in(res_in), .res_vld(res_vld),
        .dist_outer(dist_outer), .dist_inner(dist_inner), .grad_wt(grad_wt),
        .dist_vld(dist_vld), .hold(hold), .res_out(res_out),
        .res_out_vld(res_out_vld), .coef_out(coef_out)
    );

    int    n_run = 0, n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R2";

    // behavioural reference state
    longint m_coef = 0, m_e = 0, m_g = 0, m_p = 0;
    int     m_phase = 0;          // 0 listen, 1 multiply, 2 commit, 3 frozen
    longint raw_q[$];
    bit     vld_q[$];

    function automatic longint clampv(longint v, longint lo, longint hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic longint raw_corr(longint r, longint c);
        longint s, u, t;
        s = (r * r) >>> (RW - 1);
        u = (s * r) >>> (RW - 1);
        t = (c * u) >>> CF;
        return r - t;
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_coef = 0; m_phase = 0; m_e = 0; m_g = 0; m_p = 0;
            raw_q.delete(); vld_q.delete();
        end else begin
            raw_q.push_back(raw_corr(longint'(res_in), m_coef));
            vld_q.push_back(res_vld);
            if (raw_q.size() > 4) begin
                void'(raw_q.pop_front());
                void'(vld_q.pop_front());
            end
            if (hold) m_phase = 3;
            else case (m_phase)
                0: if (dist_vld) begin
                       m_e = longint'(dist_outer) - longint'(dist_inner);
                       m_g = longint'(grad_wt);
                       m_phase = 1;
                   end
                1: begin m_p = m_e * m_g; m_phase = 2; end
                2: begin m_coef = clampv(m_coef + (m_p >>> SHIFT), CMIN, CMAX); m_phase = 0; end
                default: m_phase = 0;
            endcase
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit     ev;
            longint rw, sv;
            ev = (vld_q.size() == 4) ? vld_q[0] : 1'b0;
            check("R4 output valid", longint'(res_out_vld), longint'(ev));
            if (ev) begin
                rw = raw_q[0];
                sv = clampv(rw, RMIN, RMAX);
                check((rw != sv) ? "R3 clamped residue" : "R2 corrected residue",
                      longint'(res_out), sv);
            end
            check({cur_req, " coefficient"}, longint'(coef_out), m_coef);
        end
    end

    task automatic tick(bit dv, longint o, longint i, longint g, bit h);
        @(negedge clk);
        res_in     = RW'($urandom);
        res_vld    = ($urandom % 4) != 0;
        dist_vld   = dv;
        dist_outer = DW'(o);
        dist_inner = DW'(i);
        grad_wt    = GW'(g);
        hold       = h;
    endtask

    task automatic push_res(longint r);
        @(negedge clk);
        res_in   = RW'(r);
        res_vld  = 1'b1;
        dist_vld = 1'b0;
        hold     = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) tick(1'b0, 0, 0, 0, 1'b0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        longint c0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", longint'(res_out_vld), 0);
        check("R1 reset coefficient", longint'(coef_out), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: zero coefficient, random and extreme residues
        cur_req = "R2";
        idle(40);
        push_res(RMIN); push_res(RMAX); push_res(0); push_res(-1);
        idle(6);

        // R5 / R9: single updates with known results
        cur_req = "R5";
        tick(1'b1, -1000, 3000, 8000, 1'b0);
        idle(4);
        check("R5 first update", longint'(coef_out), -3907);
        cur_req = "R9";
        check("R9 negative direction", longint'(coef_out < 0), 1);
        cur_req = "R5";
        tick(1'b1, 2500, 500, -1200, 1'b0);
        idle(4);
        check("R5 second update", longint'(coef_out), -4200);
        for (int k = 0; k < 20; k++) push_res(longint'(k * 200) - 2000);
        idle(5);

        // R8: offers during multiply and commit are dropped
        cur_req = "R8";
        c0 = longint'(coef_out);
        tick(1'b1, 0, 100, 8192, 1'b0);
        tick(1'b1, 5000, 0, 8192, 1'b0);
        tick(1'b1, 5000, 0, 8192, 1'b0);
        idle(3);
        check("R8 busy offers ignored", longint'(coef_out), c0 - 100);

        // R7: hold aborts an update in flight and blocks new ones
        cur_req = "R7";
        c0 = longint'(coef_out);
        tick(1'b1, 20000, 0, 20000, 1'b0);
        tick(1'b0, 0, 0, 0, 1'b1);
        for (int k = 0; k < 5; k++) tick(1'b1, 20000, 0, 20000, 1'b1);
        cur_req = "R8";
        tick(1'b1, 20000, 0, 20000, 1'b0);
        idle(4);
        check("R7 held coefficient", longint'(coef_out), c0);
        check("R8 release edge ignored", longint'(coef_out), c0);

        // R6: clamp at both ends, R3: output clamp with large coefficients
        cur_req = "R6";
        tick(1'b1, 32767, -32768, 32767, 1'b0); idle(4);
        tick(1'b1, 32767, -32768, 32767, 1'b0); idle(4);
        check("R6 upper clamp", longint'(coef_out), CMAX);
        cur_req = "R3";
        push_res(RMIN); push_res(RMAX); push_res(-2047); push_res(1500); push_res(-900);
        idle(5);
        cur_req = "R6";
        tick(1'b1, -32768, 32767, 32767, 1'b0); idle(4);
        tick(1'b1, -32768, 32767, 32767, 1'b0); idle(4);
        check("R6 lower clamp", longint'(coef_out), CMIN);
        cur_req = "R3";
        push_res(RMIN); push_res(RMAX); push_res(-2047); push_res(1800);
        idle(5);

        // mixed random traffic
        cur_req = "R5";
        for (int k = 0; k < 400; k++)
            tick(($urandom % 6) == 0,
                 longint'($urandom % 65536) - 32768,
                 longint'($urandom % 65536) - 32768,
                 longint'($urandom % 512) - 256,
                 ($urandom % 10) == 0);
        idle(6);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule